// File: doc/BRIEF.md
# Counter Status and Flag Generator

This block holds the status byte of one up/down counter axis and drives the two active-low flag pins that sit beside the counter. The counter datapath reports carry, borrow, compare-match and index events to it, along with the live count direction, the live count-enable state and two sign-change strobes. The block turns the events into sticky status bits. It derives an FLGa level from any chosen mix of those events, and it drives FLGb as a sign indicator or a direction indicator.

The control side supplies a four-bit event mask for FLGa and a select between latched and one-clock-pulse FLGa behaviour. It also supplies a two-bit source select for FLGb and single-cycle command strobes. These strobes clear the sticky bits, force the sign bit set or cleared, or perform a master clear. All state changes take effect on the clock edge after the cycle in which the inputs are presented.

Top module: `cnt_status_flags`

## Requirements
- R1: After reset or a master clear, status bits 7,6,5,4 and 0 read 0, FLGa (flga_n) reads 1 in either mode, and the sign-driven FLGb reads 0.
- R2: The status byte is laid out as bit7 carry, bit6 borrow, bit5 compare, bit4 index, bit3 live count-enable, bit2 constant 0, bit1 live up-direction, bit0 sign; bits 3 and 1 follow their inputs in the same cycle.
- R3: A carry, borrow or compare event sets its status bit on the next clock edge, and the bit then stays set through any number of idle cycles.
- R4: A clear-status strobe clears bits 7..4 on the next edge and leaves the sign bit and live bits unchanged; an event in the same cycle as the strobe wins and its bit stays set.
- R5: The index bit is set on the edge after any cycle in which idx_active is high, and it holds after idx_active falls.
- R6: The sign bit is set by a went_negative strobe and cleared by a went_positive strobe (negative wins if both are high); a sign-set command overrides everything, and a sign-clear command overrides both strobes.
- R7: flag_mask bit3 enables carry, bit2 borrow, bit1 compare and bit0 index onto FLGa; in latched mode (flga_pulse=0) flga_n is low exactly while any enabled sticky bit is set.
- R8: In pulse mode (flga_pulse=1) flga_n is low for the one clock following each cycle that carries an enabled event; events on consecutive cycles give one unbroken low period.
- R9: flgb_sel 00 drives flgb high, 01 drives the sign bit (high when negative), 10 drives the live direction (high when counting up), and 11 drives it high.
- R10: A master clear takes priority over events and commands presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_clr | input | 1 | Master clear strobe |
| ev_carry | input | 1 | Counter overflow event |
| ev_borrow | input | 1 | Counter underflow event |
| ev_compare | input | 1 | Count equals target event |
| idx_active | input | 1 | Index input at its active level |
| cnt_enabled | input | 1 | Live counting-enabled state |
| dir_up | input | 1 | Live count direction, 1 = up |
| went_negative | input | 1 | Count moved below zero |
| went_positive | input | 1 | Count moved up past zero |
| cmd_clr_status | input | 1 | Clear sticky status strobe |
| cmd_sign_set | input | 1 | Force sign bit set |
| cmd_sign_clr | input | 1 | Force sign bit cleared |
| flag_mask | input | 4 | FLGa event enables (carry, borrow, compare, index) |
| flga_pulse | input | 1 | 1 = pulse mode FLGa, 0 = latched |
| flgb_sel | input | 2 | FLGb source select |
| status | output | 8 | Status byte |
| flga_n | output | 1 | Active-low event flag |
| flgb | output | 1 | Sign or direction flag |

## Verification
Every combination of the four events is crossed with every mask value in both FLGa modes. This shows whether a masked event leaks onto the flag and whether an unmasked one reaches it, and it shows that the sticky bits and the pulse path act independently. Runs of back-to-back events in pulse mode show merging apart from one-clock pulses. Same-cycle collisions between events, clear-status, sign commands and master clear expose any wrong priority order. A sweep of every FLGb select against sign and direction shows whether each source is routed to the right code.

// File: rtl/cnt_status_flags.sv
module cnt_status_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_clr,
  input  logic       ev_carry,
  input  logic       ev_borrow,
  input  logic       ev_compare,
  input  logic       idx_active,
  input  logic       cnt_enabled,
  input  logic       dir_up,
  input  logic       went_negative,
  input  logic       went_positive,
  input  logic       cmd_clr_status,
  input  logic       cmd_sign_set,
  input  logic       cmd_sign_clr,
  input  logic [3:0] flag_mask,
  input  logic       flga_pulse,
  input  logic [1:0] flgb_sel,
  output logic [7:0] status,
  output logic       flga_n,
  output logic       flgb
);

  logic [3:0] events;
  logic [3:0] sticky;
  logic       sign_q;
  logic       pulse_q;

  assign events = {ev_carry, ev_borrow, ev_compare, idx_active};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sticky <= '0;
    else if (master_clr)     sticky <= '0;
    else if (cmd_clr_status) sticky <= events;
    else                     sticky <= sticky | events;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             sign_q <= 1'b0;
    else if (master_clr)    sign_q <= 1'b0;
    else if (cmd_sign_set)  sign_q <= 1'b1;
    else if (cmd_sign_clr)  sign_q <= 1'b0;
    else if (went_negative) sign_q <= 1'b1;
    else if (went_positive) sign_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pulse_q <= 1'b0;
    else if (master_clr) pulse_q <= 1'b0;
    else                 pulse_q <= |(events & flag_mask);
  end

  assign status = {sticky, cnt_enabled, 1'b0, dir_up, sign_q};
  assign flga_n = flga_pulse ? ~pulse_q : ~|(sticky & flag_mask);

  always_comb begin
    case (flgb_sel)
      2'b01:   flgb = sign_q;
      2'b10:   flgb = dir_up;
      default: flgb = 1'b1;
    endcase
  end

endmodule

module cnt_status_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master_clr,
  input logic       ev_carry,
  input logic       cmd_clr_status,
  input logic       cmd_sign_set,
  input logic [3:0] flag_mask,
  input logic       flga_pulse,
  input logic [1:0] flgb_sel,
  input logic [7:0] status,
  input logic       flga_n,
  input logic       flgb
);

  a_r3_carry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_carry && !master_clr) |=> status[7]);

  a_r3_carry_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !cmd_clr_status && !master_clr) |=> status[7]);

  a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr_status && !ev_carry) |=> !status[7]);

  a_r6_sign_force: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sign_set && !master_clr) |=> status[0]);

  a_r7_latched_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!flga_pulse && |(status[7:4] & flag_mask)) |-> !flga_n);

  a_r8_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
    (flga_pulse && ev_carry && flag_mask[3] && !master_clr) |=> (!flga_n || !flga_pulse));

  a_r9_flgb_off: assert property (@(posedge clk) disable iff (!rst_n)
    (flgb_sel == 2'b00) |-> flgb);

  a_r10_master_wins: assert property (@(posedge clk) disable iff (!rst_n)
    master_clr |=> (status[7:4] == 4'b0000 && !status[0]));

endmodule

bind cnt_status_flags cnt_status_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_clr(master_clr), .ev_carry(ev_carry),
  .cmd_clr_status(cmd_clr_status), .cmd_sign_set(cmd_sign_set),
  .flag_mask(flag_mask), .flga_pulse(flga_pulse), .flgb_sel(flgb_sel),
  .status(status), .flga_n(flga_n), .flgb(flgb)
);

// File: tb/tb_cnt_status_flags.sv
`timescale 1ns/1ps
module tb_cnt_status_flags;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_clr = 0, ev_carry = 0, ev_borrow = 0, ev_compare = 0, idx_active = 0;
  logic cnt_enabled = 0, dir_up = 0, went_negative = 0, went_positive = 0;
  logic cmd_clr_status = 0, cmd_sign_set = 0, cmd_sign_clr = 0;
  logic [3:0] flag_mask = 0;
  logic flga_pulse = 0;
  logic [1:0] flgb_sel = 0;
  logic [7:0] status;
  logic flga_n, flgb;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cnt_status_flags dut (
    .clk(clk), .rst_n(rst_n), .master_clr(master_clr), .ev_carry(ev_carry),
    .ev_borrow(ev_borrow), .ev_compare(ev_compare), .idx_active(idx_active),
    .cnt_enabled(cnt_enabled), .dir_up(dir_up), .went_negative(went_negative),
    .went_positive(went_positive), .cmd_clr_status(cmd_clr_status),
    .cmd_sign_set(cmd_sign_set), .cmd_sign_clr(cmd_sign_clr),
    .flag_mask(flag_mask), .flga_pulse(flga_pulse), .flgb_sel(flgb_sel),
    .status(status), .flga_n(flga_n), .flgb(flgb)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ev(input logic [3:0] e);
    {ev_carry, ev_borrow, ev_compare, idx_active} = e;
  endtask

  task automatic mclear();
    master_clr = 1; tick(); master_clr = 0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    flgb_sel = 2'b01;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset status", {status[7:4], status[0]}, 0);
    check("R1 reset flga", flga_n, 1);
    check("R1 reset flgb sign", flgb, 0);
    flga_pulse = 1;
    #0 check("R1 reset flga pulse", flga_n, 1);
    flga_pulse = 0;

    for (int en = 0; en < 2; en++)
      for (int up = 0; up < 2; up++) begin
        cnt_enabled = en[0]; dir_up = up[0];
        #1;
        check("R2 live bits", {status[3], status[2], status[1]}, {en[0], 1'b0, up[0]});
      end

    // latched sweep
    for (int m = 0; m < 16; m++)
      for (int e = 0; e < 16; e++) begin
        flag_mask = m[3:0];
        mclear();
        set_ev(e[3:0]); tick(); set_ev(4'h0);
        check("R3 sticky set", status[7:4], e);
        check("R7 latched flga", flga_n, ((e & m) != 0) ? 0 : 1);
        tick();
        check("R3 sticky hold", status[7:4], e);
        cmd_clr_status = 1; tick(); cmd_clr_status = 0;
        check("R4 clear", status[7:4], 0);
        check("R7 flga released", flga_n, 1);
      end

    // pulse sweep
    flga_pulse = 1;
    for (int m = 0; m < 16; m++)
      for (int e = 0; e < 16; e++) begin
        flag_mask = m[3:0];
        set_ev(e[3:0]); tick(); set_ev(4'h0);
        check("R8 pulse low", flga_n, ((e & m) != 0) ? 0 : 1);
        check("R3 sticky in pulse mode", status[7:4], e);
        tick();
        check("R8 pulse one clock", flga_n, 1);
        mclear();
      end

    flag_mask = 4'b1000;
    ev_carry = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R8 merged low", flga_n, 0);
    end
    ev_carry = 0; tick();
    check("R8 merged end", flga_n, 1);
    flga_pulse = 0;
    mclear();

    // R4 collision
    ev_borrow = 1; tick(); ev_borrow = 0;
    set_ev(4'b1000); cmd_clr_status = 1; tick(); set_ev(0); cmd_clr_status = 0;
    check("R4 event wins", status[7:4], 4'b1000);

    // R4 sign untouched by clear
    cmd_sign_set = 1; tick(); cmd_sign_set = 0;
    cmd_clr_status = 1; tick(); cmd_clr_status = 0;
    check("R4 sign kept", status[0], 1);

    // R5 index level
    mclear();
    idx_active = 1; tick(); tick(); idx_active = 0; tick();
    check("R5 index held", status[4], 1);

    // R6 sign
    mclear();
    went_negative = 1; tick(); went_negative = 0;
    check("R6 neg sets", status[0], 1);
    went_positive = 1; tick(); went_positive = 0;
    check("R6 pos clears", status[0], 0);
    went_negative = 1; went_positive = 1; tick(); went_negative = 0; went_positive = 0;
    check("R6 neg wins", status[0], 1);
    cmd_sign_clr = 1; went_negative = 1; tick(); cmd_sign_clr = 0; went_negative = 0;
    check("R6 clr cmd wins", status[0], 0);
    cmd_sign_set = 1; cmd_sign_clr = 1; went_positive = 1; tick();
    cmd_sign_set = 0; cmd_sign_clr = 0; went_positive = 0;
    check("R6 set cmd wins", status[0], 1);

    // R9 flgb sweep
    for (int s = 0; s < 4; s++)
      for (int sg = 0; sg < 2; sg++)
        for (int d = 0; d < 2; d++) begin
          if (sg != 0) cmd_sign_set = 1; else cmd_sign_clr = 1;
          tick(); cmd_sign_set = 0; cmd_sign_clr = 0;
          flgb_sel = s[1:0]; dir_up = d[0];
          #1;
          check("R9 flgb", flgb, (s == 1) ? sg : (s == 2) ? d : 1);
        end

    // R10 master clear priority
    flgb_sel = 2'b01;
    master_clr = 1; set_ev(4'hF); cmd_sign_set = 1; went_negative = 1;
    tick();
    master_clr = 0; set_ev(0); cmd_sign_set = 0; went_negative = 0;
    check("R10 master wins status", {status[7:4], status[0]}, 0);
    check("R1 flgb after master", flgb, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule